// File: doc/BRIEF.md
# Local Interrupt Timer

A per-processor countdown timer for a local interrupt controller. Software programs three things through a small write port: a timer entry, made of an interrupt vector, a mask bit and a periodic/one-shot bit; a divide selector that sets how many input clocks make one timer tick; and a 32-bit initial count. Writing the initial count arms the timer. The write cycle is the load instant, and counting starts from it.

The block shows the current count at all times. When the programmed number of ticks has elapsed, it raises a single-cycle expiry pulse carrying the vector. In periodic mode it then starts the next period at once. In one-shot mode it fires once and goes idle. Expiry is an event, so it has no valid/ready handshake and cannot be back-pressured: a consumer that is not listening misses the pulse. The write port and the count output are plain control and status pins with no handshake. A write is taken on every rising clock edge where `wr_en` is high.

Top module: `irq_timer`

## Requirements
- R1: After reset the entry is masked, its vector is 0 and its mode is one-shot, the divide shift is 0, the timer is idle, `cur_count` reads 0 and `expire_pulse` is low.
- R2: The load edge is the clock edge that takes a write with `wr_sel`=2. One tick lasts 2^shift clocks after that edge. Between the load edge and expiry, `cur_count` reads N minus the ticks elapsed in the current period, where N is the loaded value, so it reads N right after the load edge.
- R3: In one-shot mode (entry bit 17 = 0), expiry falls exactly (N+1)·2^shift clocks after the load edge and happens only once. From that point on `cur_count` reads 0.
- R4: In periodic mode (entry bit 17 = 1) with N > 0, expiry repeats every (N+1)·2^shift clocks, counted from the load edge, and `cur_count` reloads to N at each expiry.
- R5: A load of N = 0 while the mode is periodic leaves the timer idle: no pulse is produced and `cur_count` reads 0.
- R6: While the entry mask (bit 16) is 1, no expiry pulse is produced, but counting goes on and the periods keep their phase.
- R7: A write with `wr_sel`=1 sets the divide shift to `wr_data[2:0]` (shift 0 to 7). The new shift is used only from the next count load; a timer that is already running keeps its old tick length.
- R8: A count write while the timer is running discards the old count and starts a new one from the write edge with the new value.
- R9: The expiry pulse lasts one clock per expiry. While it is high, `expire_vec` carries the entry vector (`wr_data[7:0]` of a `wr_sel`=0 write) as it was at the expiry edge.
- R10: A write with `wr_sel`=3 is ignored and changes neither the timer nor its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 entry, 1 divide, 2 initial count, 3 none |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Current count |
| expire_pulse | output | 1 | One-cycle expiry pulse |
| expire_vec | output | 8 | Vector that goes with the pulse |

## Verification
A wrong prescaler phase or tick counter shows up in `cur_count` within one tick of the load, long before it moves the expiry pulse. A lost or stale run flag shows up as a count that is nonzero when it should read zero, or as a pulse in the cycle right after the expiry instant. The reference model works out every expected pulse instant from the load edge, the shift and the count alone. The bench compares the count, the pulse and the vector on every clock, so any fault is caught in the first cycle it reaches a port.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

  localparam int VEC_W    = 8;
  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } wsel_e;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } entry_t;

endpackage

// File: rtl/irq_timer_regs.sv
module irq_timer_regs
  import irq_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output entry_t           entry,
  output logic [DIV_W-1:0] div_shift,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  always_ff @(posedge clk) begin
    if (rst) begin
      entry     <= '{periodic: 1'b0, mask: 1'b1, vec: '0};
      div_shift <= '0;
    end else if (wr_en) begin
      case (wsel_e'(wr_sel))
        SEL_ENTRY: entry <= '{periodic: wr_data[MODE_BIT], mask: wr_data[MASK_BIT],
                              vec: wr_data[VEC_W-1:0]};
        SEL_DIV:   div_shift <= wr_data[DIV_W-1:0];
        default:   ;
      endcase
    end
  end

  assign load     = wr_en && (wsel_e'(wr_sel) == SEL_COUNT);
  assign load_val = wr_data;

  // R1
  reset_masked_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (entry.mask && div_shift == '0));

endmodule

// File: rtl/irq_timer_presc.sv
module irq_timer_presc #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] shift_in,
  output logic             tick_en
);

  localparam int PRESC_W = (1 << DIV_W) - 1;

  logic [PRESC_W-1:0] presc;
  logic [DIV_W-1:0]   shift_q;
  logic [PRESC_W-1:0] limit;

  assign limit   = PRESC_W'((32'd1 << shift_q) - 32'd1);
  assign tick_en = run && (presc == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      presc   <= '0;
      shift_q <= '0;
    end else if (load) begin
      presc   <= '0;
      shift_q <= shift_in;
    end else if (run) begin
      presc <= tick_en ? '0 : presc + 1'b1;
    end
  end

  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en || load) |=> (presc == '0));

  // R7
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(shift_q));

endmodule

// File: rtl/irq_timer_core.sv
module irq_timer_core
  import irq_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  entry_t           entry,
  input  logic             tick_en,
  output logic             run,
  output logic [CNT_W-1:0] cur_count,
  output logic             fire,
  output logic [VEC_W-1:0] fire_vec
);

  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] ticks;
  logic             expire;

  assign expire    = tick_en && (ticks == n_q);
  assign cur_count = run ? (n_q - ticks) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      n_q      <= '0;
      ticks    <= '0;
      fire     <= 1'b0;
      fire_vec <= '0;
    end else begin
      fire <= expire && !entry.mask;
      if (expire) fire_vec <= entry.vec;
      if (load) begin
        n_q   <= load_val;
        ticks <= '0;
        run   <= !(entry.periodic && load_val == '0);
      end else if (expire) begin
        ticks <= '0;
        if (!entry.periodic) run <= 1'b0;
      end else if (tick_en) begin
        ticks <= ticks + 1'b1;
      end
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (ticks <= n_q));

  // R3
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !entry.periodic && !load) |=> (!run && cur_count == '0));

  // R5
  zero_period_off_chk: assert property (@(posedge clk) disable iff (rst)
    (load && entry.periodic && load_val == '0) |=> !run);

  // R6
  masked_silent_chk: assert property (@(posedge clk) disable iff (rst)
    entry.mask |=> !fire);

endmodule

// File: rtl/irq_timer.sv
module irq_timer
  import irq_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  output logic [31:0]      cur_count,
  output logic             expire_pulse,
  output logic [7:0]       expire_vec
);

  entry_t           entry;
  logic [DIV_W-1:0] div_shift;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             run;
  logic             tick_en;

  irq_timer_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .entry(entry), .div_shift(div_shift), .load(load), .load_val(load_val)
  );

  irq_timer_presc #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .load(load), .run(run), .shift_in(div_shift),
    .tick_en(tick_en)
  );

  irq_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .entry(entry),
    .tick_en(tick_en), .run(run), .cur_count(cur_count),
    .fire(expire_pulse), .fire_vec(expire_vec)
  );

endmodule

// File: tb/test_irq_timer.sv
module test_irq_timer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_count;
  logic        expire_pulse;
  logic [7:0]  expire_vec;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_timer i_irq_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_count(cur_count), .expire_pulse(expire_pulse), .expire_vec(expire_vec)
  );

  // behavioural reference model
  longint cyc = 0, ld_cyc = 0, ld_n = 0, d, p;
  int     ld_sh = 0, m_div = 0, m_vec = 0, exp_vec = 0;
  bit     m_mask = 1, m_per = 0, m_run = 0, exp_fire = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_mask = 1; m_per = 0; m_vec = 0; m_div = 0; m_run = 0;
      ld_n = 0; ld_sh = 0; exp_fire = 0; exp_vec = 0;
    end else begin
      exp_fire = 0;
      if (m_run) begin
        d = cyc - ld_cyc;
        p = (ld_n + 1) << ld_sh;
        if (d > 0 && d % p == 0) begin
          exp_fire = !m_mask;
          exp_vec  = m_vec;
          if (!m_per) m_run = 0;
        end
      end
      if (wr_en) begin
        if (wr_sel == 2'd0) begin
          m_vec = int'(wr_data[7:0]); m_mask = wr_data[16]; m_per = wr_data[17];
        end else if (wr_sel == 2'd1) begin
          m_div = int'(wr_data[2:0]);
        end else if (wr_sel == 2'd2) begin
          ld_n = longint'(wr_data); ld_sh = m_div; ld_cyc = cyc;
          m_run = !(m_per && wr_data == 0);
        end
      end
    end
  end

  task automatic check(input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    longint ec;
    if (!rst) begin
      ec = m_run ? ld_n - (((cyc - ld_cyc) >> ld_sh) % (ld_n + 1)) : 0;
      check("cur_count", longint'(cur_count), ec);
      check("expire_pulse", longint'(expire_pulse), longint'(exp_fire));
      if (exp_fire) check("expire_vec", longint'(expire_vec), longint'(exp_vec));
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ent(input bit per, input bit msk, input logic [7:0] v);
    return {14'd0, per, msk, 8'd0, v};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1"; idle(6);
    cur_req = "R3"; wr(2'd0, ent(0, 0, 8'h21)); wr(2'd1, 32'd1); wr(2'd2, 32'd3); idle(24);
    cur_req = "R9"; wr(2'd1, 32'd0); wr(2'd2, 32'd0); idle(5);
    cur_req = "R4"; wr(2'd0, ent(1, 0, 8'h40)); wr(2'd1, 32'd2); wr(2'd2, 32'd2); idle(45);
    cur_req = "R5"; wr(2'd2, 32'd0); idle(12);
    cur_req = "R6"; wr(2'd0, ent(1, 1, 8'h55)); wr(2'd1, 32'd0); wr(2'd2, 32'd1); idle(10);
    wr(2'd0, ent(1, 0, 8'h56)); idle(8);
    cur_req = "R7"; wr(2'd1, 32'd1); wr(2'd2, 32'd3); idle(5);
    wr(2'd1, 32'd3); idle(20); wr(2'd2, 32'd1); idle(40);
    cur_req = "R8"; wr(2'd1, 32'd0); wr(2'd2, 32'd9); idle(4); wr(2'd2, 32'd5); idle(20);
    cur_req = "R10"; wr(2'd3, 32'hFFFF_FFFF); idle(15);
    cur_req = "R3"; wr(2'd0, ent(0, 0, 8'h77)); wr(2'd1, 32'd7); wr(2'd2, 32'd0); idle(300);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule